// File: doc/BRIEF.md
# Interrupt Source PQ State Controller

This block keeps the delivery state of a small array of interrupt sources. Each source has a two-bit state, written here as PQ. P marks a notification that has been sent and not yet acknowledged. Q marks a further trigger that arrived while P was set. A per-source configuration input selects how each source behaves. A message-style source is triggered by a high input cycle or by a software write. A level-sensitive source follows the level of its input line and never records a Q. Both kinds share one state machine.

Software reaches each source through a register port. Every source owns two pages. The even page is the trigger page. The odd page is the management page, which offers end-of-interrupt (EOI), get and set. Each access gets a response in the next cycle. Whenever a source decides to notify, its number goes into a pending set. The pending numbers leave one at a time through a single-entry valid/ready output, lowest number first, toward a downstream router.

Top module: `irq_pq_ctrl`

## Requirements
- R1: After reset every source's PQ reads 2'b01 (off). No notification is produced until software changes a state.
- R2: A source in state 01 ignores triggers. Its state stays 01 and it does not notify.
- R3: For a message-style source, each cycle with its line high runs the trigger. The same happens for each write to its trigger page. The trigger maps 00 to 10 with one notification, 10 to 11, 11 to 11 and 01 to 01. A low line has no effect.
- R4: For a level source, a change of its line updates the recorded assertion and re-evaluates the source. It fires only when the line is high and PQ is 00. Firing sets PQ to 10 and sends one notification. A level change never sets Q, and a falling line never notifies.
- R5: An EOI always leaves PQ at 00. If Q was set, the EOI sends one notification and its response has bit 0 set. Otherwise bit 0 is 0 and nothing is sent.
- R6: An EOI on a level source whose line is still high sends a new notification and leaves PQ at 10. With the line low it leaves PQ at 00 and sends nothing.
- R7: A get returns PQ in response bits 1:0. A set write loads write-data bits 1:0 into PQ and returns the previous PQ. A response is valid exactly one cycle after each accepted request, and only then.
- R8: The address is {source, page, op}, with the page in bit 2 and the op in bits 1:0. Page 0 is the trigger page. Page 1 ops are 00 EOI, 01 get, 10 set (a read of op 10 acts as a get), and 11 has no effect. A trigger-page write is ignored by a level source.
- R9: The notification output holds valid with the source number stable until ready is high. When several sources are pending, the lowest-numbered one is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | NUM_SRC | Per-source type: 1 = level-sensitive, 0 = message-style |
| src_line | input | NUM_SRC | Per-source trigger lines |
| reg_valid | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | SRC_W+3 | {source, page, op} |
| reg_wdata | input | 2 | New PQ for a set |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| rsp_data | output | 2 | Response value |
| notify_valid | output | 1 | A notification is offered |
| notify_ready | input | 1 | Downstream accepts the notification |
| notify_src | output | SRC_W | Number of the notifying source |

## Verification
The bench targets the ways the trigger state can be lost or doubled. A second and third trigger must pile into Q without a second notification, and a design that notified on 10 would leave an extra item in the scoreboard. EOI on a level source is exercised with the line both high and low. A design that skipped the re-evaluation would miss a notification, and one that ignored the line would produce a spurious one. A toggle of the level line while P is set checks that Q stays clear, and a trigger-page write to a level source must change nothing. Three sources are fired together while ready is held low. A wrong priority or an unstable held output shows up as a scoreboard mismatch or as a changed source number.

// File: rtl/irq_pq_pkg.sv
// Shared types and helpers for the interrupt source PQ state controller.
// Assumes PQ is two bits: bit 1 = P (sent), bit 0 = Q (queued).
package irq_pq_pkg;

    localparam logic [1:0] PQ_IDLE = 2'b00;
    localparam logic [1:0] PQ_OFF  = 2'b01;
    localparam logic [1:0] PQ_SENT = 2'b10;

    // Operation decoded from one register access, applied to one source.
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_TRIG = 3'd1,
        OP_EOI  = 3'd2,
        OP_GET  = 3'd3,
        OP_SET  = 3'd4
    } src_op_e;

    // Message trigger step: 00->10, 10->11, 11->11, 01->01.
    function automatic logic [1:0] msg_step(input logic [1:0] pq);
        return (pq == PQ_OFF) ? PQ_OFF : {1'b1, pq[1]};
    endfunction

endpackage

// File: rtl/irq_pq_cell.sv
// One interrupt source: holds PQ and the level assertion flag.
// Applies this cycle's register op first, then the line event, to the result.
// Raises notify for one cycle whenever any of those steps decides to notify.
module irq_pq_cell
    import irq_pq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_level,
    input  logic       line_in,
    input  logic       sel,
    input  src_op_e    op,
    input  logic [1:0] set_val,
    output logic [1:0] pq,
    output logic       eoi_q_hit,
    output logic       notify
);

    logic [1:0] pq_q, pq_after_op, pq_next;
    logic       asserted_q;
    logic       op_notify, line_notify, level_eval;

    // Register-op step: trigger, EOI or set on the current state.
    always_comb begin
        pq_after_op = pq_q;
        op_notify   = 1'b0;
        eoi_q_hit   = 1'b0;
        if (sel) begin
            unique case (op)
                OP_TRIG: if (!is_level) begin
                    op_notify   = (pq_q == PQ_IDLE);
                    pq_after_op = msg_step(pq_q);
                end
                OP_EOI: begin
                    eoi_q_hit   = pq_q[0];
                    op_notify   = pq_q[0];
                    pq_after_op = PQ_IDLE;
                end
                OP_SET:  pq_after_op = set_val;
                default: pq_after_op = pq_q;
            endcase
        end
    end

    // Line step: message trigger on a high line, or level re-evaluation.
    always_comb begin
        pq_next     = pq_after_op;
        line_notify = 1'b0;
        level_eval  = (line_in != asserted_q) || (sel && op == OP_EOI);
        if (!is_level) begin
            if (line_in) begin
                line_notify = (pq_after_op == PQ_IDLE);
                pq_next     = msg_step(pq_after_op);
            end
        end else if (level_eval && line_in && pq_after_op == PQ_IDLE) begin
            pq_next     = PQ_SENT;
            line_notify = 1'b1;
        end
    end

    // State registers: reset turns the source off and clears the assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq_q       <= PQ_OFF;
            asserted_q <= 1'b0;
        end else begin
            pq_q       <= pq_next;
            asserted_q <= is_level & line_in;
        end
    end

    assign pq     = pq_q;
    assign notify = op_notify | line_notify;

endmodule

// File: rtl/irq_pq_notify_arb.sv
// Collects per-source notify requests into a pending set and offers them,
// lowest number first, through a one-entry valid/ready output register.
// Requests for a source already pending merge into its single pending bit.
module irq_pq_notify_arb #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [SRC_W-1:0]   out_src
);

    logic [NUM_SRC-1:0] pend_q, grant_mask;
    logic [SRC_W-1:0]   grant_idx;
    logic               grant_any, take;

    // Find the lowest pending source.
    always_comb begin
        grant_idx = '0;
        grant_any = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant_idx = SRC_W'(i);
                grant_any = 1'b1;
            end
        end
    end

    assign take       = !out_valid || out_ready;
    assign grant_mask = (take && grant_any) ? (NUM_SRC'(1) << grant_idx) : '0;

    // Pending set and output register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            out_valid <= 1'b0;
            out_src   <= '0;
        end else begin
            pend_q <= (pend_q & ~grant_mask) | req;
            if (take) begin
                out_valid <= grant_any;
                out_src   <= grant_idx;
            end
        end
    end

endmodule

// File: rtl/irq_pq_ctrl.sv
// Top of the interrupt source PQ state controller. Decodes register
// accesses into per-source ops, instantiates one cell per source, registers
// the response, and funnels notifications through the arbiter.
// Assumes src_level is static configuration driven from outside.
module irq_pq_ctrl
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter int ADDR_W  = SRC_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic               reg_valid,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [1:0]         reg_wdata,
    output logic               rsp_valid,
    output logic [1:0]         rsp_data,
    output logic               notify_valid,
    input  logic               notify_ready,
    output logic [SRC_W-1:0]   notify_src
);

    logic [SRC_W-1:0]   acc_src;
    logic               acc_mgmt, acc_hit;
    logic [1:0]         acc_sub;
    src_op_e            acc_op;
    logic [1:0]         pq_vec   [NUM_SRC];
    logic [NUM_SRC-1:0] eoi_hit_vec, notify_vec;
    logic [1:0]         rsp_next;

    assign acc_src  = reg_addr[ADDR_W-1:3];
    assign acc_mgmt = reg_addr[2];
    assign acc_sub  = reg_addr[1:0];
    assign acc_hit  = reg_valid && (int'(acc_src) < NUM_SRC);

    // Decode the access into one operation.
    always_comb begin
        acc_op = OP_NONE;
        if (acc_hit) begin
            if (!acc_mgmt) begin
                acc_op = reg_we ? OP_TRIG : OP_NONE;
            end else begin
                unique case (acc_sub)
                    2'b00:   acc_op = OP_EOI;
                    2'b01:   acc_op = OP_GET;
                    2'b10:   acc_op = reg_we ? OP_SET : OP_GET;
                    default: acc_op = OP_NONE;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_pq_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .is_level  (src_level[g]),
            .line_in   (src_line[g]),
            .sel       (acc_hit && acc_src == SRC_W'(g)),
            .op        (acc_op),
            .set_val   (reg_wdata),
            .pq        (pq_vec[g]),
            .eoi_q_hit (eoi_hit_vec[g]),
            .notify    (notify_vec[g])
        );
    end

    // Select the response value of the addressed source.
    always_comb begin
        rsp_next = 2'b00;
        if (acc_hit) begin
            unique case (acc_op)
                OP_EOI:         rsp_next = {1'b0, eoi_hit_vec[acc_src]};
                OP_GET, OP_SET: rsp_next = pq_vec[acc_src];
                default:        rsp_next = 2'b00;
            endcase
        end
    end

    // Response register: valid one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= 2'b00;
        end else begin
            rsp_valid <= reg_valid;
            rsp_data  <= rsp_next;
        end
    end

    irq_pq_notify_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (notify_vec),
        .out_valid (notify_valid),
        .out_ready (notify_ready),
        .out_src   (notify_src)
    );

endmodule

// File: rtl/irq_pq_ctrl_chk.sv
// Protocol checker for irq_pq_ctrl, attached by bind below.
module irq_pq_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_valid,
    input logic             rsp_valid,
    input logic             notify_valid,
    input logic             notify_ready,
    input logic [SRC_W-1:0] notify_src
);

    // R7: every request is answered in the next cycle
    p_rsp_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid |=> rsp_valid);

    // R7: no response without a request
    p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_valid |=> !rsp_valid);

    // R9: an offered notification is held until accepted
    p_notify_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (notify_valid && !notify_ready) |=> (notify_valid && $stable(notify_src)));

    // R9: the offered source number is a real source
    p_notify_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> (int'(notify_src) < NUM_SRC));

endmodule

bind irq_pq_ctrl irq_pq_ctrl_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_valid    (reg_valid),
    .rsp_valid    (rsp_valid),
    .notify_valid (notify_valid),
    .notify_ready (notify_ready),
    .notify_src   (notify_src)
);

// File: tb/irq_pq_ctrl_test.sv
// Scoreboard bench: stimulus tasks push expected notifications, a monitor
// pops and compares them as they leave the design.
module irq_pq_ctrl_test;

    localparam int NUM_SRC = 8;
    localparam int SRC_W   = 3;
    localparam int ADDR_W  = SRC_W + 3;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_SRC-1:0] src_level;
    logic [NUM_SRC-1:0] src_line;
    logic               reg_valid, reg_we;
    logic [ADDR_W-1:0]  reg_addr;
    logic [1:0]         reg_wdata;
    logic               rsp_valid;
    logic [1:0]         rsp_data;
    logic               notify_valid, notify_ready;
    logic [SRC_W-1:0]   notify_src;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    irq_pq_ctrl #(.NUM_SRC(NUM_SRC)) uut (
        .clk (clk), .rst_n (rst_n), .src_level (src_level), .src_line (src_line),
        .reg_valid (reg_valid), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .notify_valid (notify_valid), .notify_ready (notify_ready),
        .notify_src (notify_src)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_notify(input int src, input string req);
        exp_q.push_back(src);
        tag_q.push_back(req);
    endtask

    // Monitor: compare each accepted notification with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && notify_valid && notify_ready) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R9 unexpected notification: actual %0d expected none",
                         notify_src);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (int'(notify_src) != e) begin
                    n_fails++;
                    $display("FAIL %s notification: actual %0d expected %0d",
                             t, notify_src, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One register access; checks the response arrives one cycle later (R7).
    task automatic access(input bit we, input int src, input bit mgmt,
                          input bit [1:0] sub, input bit [1:0] wd,
                          output bit [1:0] rd);
        reg_valid = 1'b1;
        reg_we    = we;
        reg_addr  = {SRC_W'(src), mgmt, sub};
        reg_wdata = wd;
        @(posedge clk);
        #1;
        reg_valid = 1'b0;
        @(negedge clk);
        check("R7 response valid", int'(rsp_valid), 1);
        rd = rsp_data;
        @(posedge clk);
        #1;
    endtask

    task automatic get_pq(input int src, input int exp, input string req);
        bit [1:0] rd;
        access(1'b0, src, 1'b1, 2'b01, 2'b00, rd);
        check(req, int'(rd), exp);
    endtask

    task automatic set_pq(input int src, input bit [1:0] val, input int old_exp);
        bit [1:0] rd;
        access(1'b1, src, 1'b1, 2'b10, val, rd);
        check("R7 set returns old PQ", int'(rd), old_exp);
    endtask

    task automatic eoi(input bit we, input int src, input int bit0_exp, input string req);
        bit [1:0] rd;
        access(we, src, 1'b1, 2'b00, 2'b00, rd);
        check(req, int'(rd), bit0_exp);
    endtask

    task automatic pulse(input logic [NUM_SRC-1:0] mask);
        src_line = src_line | mask;
        @(posedge clk);
        #1;
        src_line = src_line & ~mask;
    endtask

    task automatic level(input int src, input bit v);
        src_line[src] = v;
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        bit [1:0] rd;
        rst_n        = 1'b0;
        src_level    = 8'b1100_0000;
        src_line     = '0;
        reg_valid    = 1'b0;
        reg_we       = 1'b0;
        reg_addr     = '0;
        reg_wdata    = '0;
        notify_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(1);

        // R1: all sources off after reset
        for (int s = 0; s < NUM_SRC; s++) get_pq(s, 1, "R1 reset PQ");

        // R2: trigger on an off source does nothing
        pulse(8'h01);
        idle(4);
        get_pq(0, 1, "R2 off stays off");

        // R3: message trigger sequence 00 -> 10 -> 11 -> 11
        set_pq(0, 2'b00, 1);
        pulse(8'h01);
        expect_notify(0, "R3");
        idle(4);
        get_pq(0, 2, "R3 first trigger");
        pulse(8'h01);
        idle(4);
        get_pq(0, 3, "R3 second trigger queues");
        pulse(8'h01);
        idle(4);
        get_pq(0, 3, "R3 third trigger");

        // R5: EOI with Q set notifies and reports bit 0
        expect_notify(0, "R5");
        eoi(1'b1, 0, 1, "R5 EOI bit0 with Q");
        idle(4);
        get_pq(0, 0, "R5 EOI leaves 00");
        eoi(1'b0, 0, 0, "R5 EOI bit0 without Q");
        idle(4);

        // R8: trigger page write on message and level sources
        set_pq(1, 2'b00, 1);
        expect_notify(1, "R8");
        access(1'b1, 1, 1'b0, 2'b00, 2'b00, rd);
        idle(4);
        get_pq(1, 2, "R8 trigger page message");
        set_pq(6, 2'b00, 1);
        access(1'b1, 6, 1'b0, 2'b00, 2'b00, rd);
        idle(4);
        get_pq(6, 0, "R8 trigger page ignored by level source");
        access(1'b1, 1, 1'b1, 2'b11, 2'b00, rd);
        get_pq(1, 2, "R8 reserved op no effect");

        // R4: level rise fires once
        expect_notify(6, "R4");
        level(6, 1'b1);
        idle(4);
        get_pq(6, 2, "R4 level rise");

        // R6: EOI while still asserted re-notifies
        expect_notify(6, "R6");
        eoi(1'b0, 6, 0, "R6 EOI bit0 level");
        idle(4);
        get_pq(6, 2, "R6 re-notify state");
        level(6, 1'b0);
        idle(2);
        eoi(1'b1, 6, 0, "R6 EOI after drop bit0");
        idle(4);
        get_pq(6, 0, "R6 EOI after drop");

        // R4: toggling while P set never sets Q
        expect_notify(6, "R4");
        level(6, 1'b1);
        idle(3);
        level(6, 1'b0);
        idle(2);
        level(6, 1'b1);
        idle(4);
        get_pq(6, 2, "R4 no Q on level");

        // R9: three sources at once, ready held low
        set_pq(2, 2'b00, 1);
        set_pq(3, 2'b00, 1);
        set_pq(5, 2'b00, 1);
        notify_ready = 1'b0;
        pulse(8'h2C);
        idle(2);
        @(negedge clk);
        check("R9 held valid", int'(notify_valid), 1);
        check("R9 lowest first", int'(notify_src), 2);
        @(negedge clk);
        check("R9 stable src", int'(notify_src), 2);
        @(posedge clk);
        #1;
        expect_notify(2, "R9");
        expect_notify(3, "R9");
        expect_notify(5, "R9");
        notify_ready = 1'b1;
        idle(6);

        // R3: a low line does nothing
        set_pq(4, 2'b00, 1);
        idle(5);
        get_pq(4, 0, "R3 low line no effect");

        idle(5);
        check("R9 scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule